// File: doc/BRIEF.md
# Power-Control Register Overlay for the Clock Data Port

This block is a bank of 256 byte-wide power-control registers that shares the data port of the real-time clock. It has no index register of its own. The address of every access is the index that the clock's index register already holds. A bank-enable input picks the target of each data-port access. When it is low, reads and writes pass through to the ordinary clock RAM. When it is high, they land in this bank, and the clock RAM sees no strobe.

Software may write only a few indices. Which ones depends on a silicon-variant parameter. The early variant has a narrow writable window. The later variant opens three more indices. Index 0x06 is a latched status byte: a read returns its value and then clears it. Every register resets to zero except a small set of per-variant defaults.

Index 0x03, bit 6, arms a soft-off path. While that bit is set, a trigger written to the companion control register produces a one-cycle power-off request. Contents that would be saved to non-volatile storage are restored through a plain preload port. The preload port can write any index.

Top module: `pwrctl_bank`

## Requirements
- R1: After reset every index reads 0x00 except the variant defaults. The early variant (LATE_SILICON=0) holds 0x03=0x80, 0x04=0x38 and 0x07=0x01. The later variant (LATE_SILICON=1) holds only 0x04=0x08.
- R2: With bank_en high, a data-port write to index 0x02, 0x03 or 0x04 stores dp_wdata in both variants. The new value is visible on dp_rdata from the next cycle.
- R3: Index 0x05, 0x07 or 0x08 accepts a data-port write only when LATE_SILICON=1. In the early variant such a write leaves the stored value unchanged.
- R4: A data-port write to any other index, including 0x06, leaves the bank unchanged.
- R5: With bank_en high, dp_rdata shows the current value of index 0x06 while dp_rd is asserted at index 0x06. From the next cycle that index reads 0x00.
- R6: With bank_en low, dp_rdata equals cmos_rdata, and cmos_wr and cmos_rd follow dp_wr and dp_rd. The bank is neither written nor cleared by such accesses.
- R7: With bank_en high, dp_rdata is the stored byte at dp_idx, and cmos_wr and cmos_rd stay low.
- R8: pwr_off_req rises for exactly one cycle, one cycle after ctl_wr and ctl_trig are first seen together while bit 6 of index 0x03 is set. It stays low when that bit is clear, and stays low for a trigger that is held.
- R9: pl_we writes pl_data to index pl_addr regardless of variant, writability or bank_en. It wins over a data-port write or a clear of the same index in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_en | input | 1 | Steers data-port accesses to this bank (1) or to the clock RAM (0) |
| dp_idx | input | 8 | Index currently held in the clock index register |
| dp_wr | input | 1 | Data-port write strobe |
| dp_rd | input | 1 | Data-port read strobe |
| dp_wdata | input | 8 | Data-port write data |
| dp_rdata | output | 8 | Data-port read data |
| cmos_rdata | input | 8 | Read data from the clock RAM |
| cmos_wr | output | 1 | Write strobe passed to the clock RAM |
| cmos_rd | output | 1 | Read strobe passed to the clock RAM |
| pl_we | input | 1 | Preload write enable |
| pl_addr | input | 8 | Preload index |
| pl_data | input | 8 | Preload data |
| ctl_wr | input | 1 | Write strobe of the companion control register |
| ctl_trig | input | 1 | Soft-off trigger bit carried by that write |
| pwr_off_req | output | 1 | One-cycle power-off request |

## Verification
The bench runs both variants side by side and aims at the edges of the writable window. If the later-variant indices leaked into the early variant, the early copy would take the value written to 0x05 or 0x07. Read-clear is checked on the read cycle itself and on the cycle after it. A design that cleared too early would show 0x00 while dp_rd is still high, and one that never cleared would hold the old byte.

A read of 0x06 with bank_en low must leave the byte intact. A design that ignored the steering would lose the status there, or would pulse the clock-RAM strobes while the bank is selected. The soft-off trigger is applied three ways: with the arm bit clear, held for two cycles, and with the trigger bit low. A missing qualification shows up as an extra or repeated pulse. Preload against a same-cycle port write to the same index shows whether the priority order is right.

// File: rtl/pwrctl_pkg.sv
package pwrctl_pkg;

    localparam int unsigned PC_AW    = 8;
    localparam int unsigned PC_DW    = 8;
    localparam int unsigned PC_DEPTH = 1 << PC_AW;

    typedef logic [PC_AW-1:0] pc_idx_t;
    typedef logic [PC_DW-1:0] pc_byte_t;

    // indices whose function other logic depends on
    localparam pc_idx_t IDX_ARM     = 8'h03;
    localparam pc_idx_t IDX_LATCH   = 8'h06;
    localparam int unsigned ARM_BIT = 6;

    typedef enum logic {
        ROUTE_CLOCK = 1'b0,
        ROUTE_BANK  = 1'b1
    } route_e;

    typedef struct packed {
        logic     wr;
        logic     rd;
        pc_idx_t  idx;
        pc_byte_t wdata;
    } port_req_t;

    typedef struct packed {
        logic     we;
        pc_idx_t  idx;
        pc_byte_t data;
    } preload_t;

    // software write permission by variant
    function automatic logic sw_writable(input logic late, input pc_idx_t idx);
        logic ok;
        ok = (idx >= 8'h02) && (idx <= 8'h04);
        if (late && ((idx == 8'h05) || (idx == 8'h07) || (idx == 8'h08)))
            ok = 1'b1;
        return ok;
    endfunction

    // per-variant reset value
    function automatic pc_byte_t reset_byte(input logic late, input pc_idx_t idx);
        pc_byte_t v;
        v = '0;
        if (late) begin
            if (idx == 8'h04) v = 8'h08;
        end else begin
            case (idx)
                8'h03:   v = 8'h80;
                8'h04:   v = 8'h38;
                8'h07:   v = 8'h01;
                default: v = '0;
            endcase
        end
        return v;
    endfunction

endpackage

// File: rtl/pwrctl_route.sv
module pwrctl_route
    import pwrctl_pkg::*;
#(
    parameter bit LATE_SILICON = 1'b1
) (
    input  logic      bank_en,
    input  port_req_t req,
    input  pc_byte_t  cmos_rdata,
    input  pc_byte_t  bank_rdata,
    output pc_byte_t  dp_rdata,
    output logic      cmos_wr,
    output logic      cmos_rd,
    output logic      bank_wr,
    output logic      bank_clr
);

    route_e route;

    always_comb begin
        route    = bank_en ? ROUTE_BANK : ROUTE_CLOCK;
        cmos_wr  = 1'b0;
        cmos_rd  = 1'b0;
        bank_wr  = 1'b0;
        bank_clr = 1'b0;
        dp_rdata = cmos_rdata;
        case (route)
            ROUTE_BANK: begin
                dp_rdata = bank_rdata;
                bank_wr  = req.wr && sw_writable(LATE_SILICON, req.idx);
                bank_clr = req.rd && (req.idx == IDX_LATCH);
            end
            default: begin
                cmos_wr = req.wr;
                cmos_rd = req.rd;
            end
        endcase
    end

endmodule

// File: rtl/pwrctl_regfile.sv
module pwrctl_regfile
    import pwrctl_pkg::*;
#(
    parameter bit LATE_SILICON = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  preload_t pl,
    input  logic     bank_wr,
    input  logic     bank_clr,
    input  pc_idx_t  idx,
    input  pc_byte_t wdata,
    output pc_byte_t rdata,
    output pc_byte_t arm_byte,
    output pc_byte_t latch_byte
);

    pc_byte_t mem [PC_DEPTH];

    // preload beats port write, port write beats read-clear
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PC_DEPTH; i++)
                mem[i] <= reset_byte(LATE_SILICON, pc_idx_t'(i));
        end else begin
            for (int i = 0; i < PC_DEPTH; i++) begin
                if (pl.we && (pl.idx == pc_idx_t'(i)))
                    mem[i] <= pl.data;
                else if (bank_wr && (idx == pc_idx_t'(i)))
                    mem[i] <= wdata;
                else if (bank_clr && (idx == pc_idx_t'(i)))
                    mem[i] <= '0;
            end
        end
    end

    assign rdata      = mem[idx];
    assign arm_byte   = mem[IDX_ARM];
    assign latch_byte = mem[IDX_LATCH];

endmodule

// File: rtl/pwrctl_softoff.sv
module pwrctl_softoff (
    input  logic clk,
    input  logic rst,
    input  logic ctl_wr,
    input  logic ctl_trig,
    input  logic armed,
    output logic pwr_off_req
);

    logic fire;
    logic fire_q;

    assign fire = ctl_wr && ctl_trig && armed;

    // single pulse on the first cycle of a qualified trigger
    always_ff @(posedge clk) begin
        if (rst) begin
            fire_q      <= 1'b0;
            pwr_off_req <= 1'b0;
        end else begin
            fire_q      <= fire;
            pwr_off_req <= fire && !fire_q;
        end
    end

endmodule

// File: rtl/pwrctl_bank.sv
module pwrctl_bank
    import pwrctl_pkg::*;
#(
    parameter bit LATE_SILICON = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bank_en,
    input  logic [7:0] dp_idx,
    input  logic       dp_wr,
    input  logic       dp_rd,
    input  logic [7:0] dp_wdata,
    output logic [7:0] dp_rdata,
    input  logic [7:0] cmos_rdata,
    output logic       cmos_wr,
    output logic       cmos_rd,
    input  logic       pl_we,
    input  logic [7:0] pl_addr,
    input  logic [7:0] pl_data,
    input  logic       ctl_wr,
    input  logic       ctl_trig,
    output logic       pwr_off_req
);

    port_req_t req;
    preload_t  pl;
    pc_byte_t  bank_rdata;
    pc_byte_t  arm_byte;
    pc_byte_t  latch_byte;
    logic      bank_wr;
    logic      bank_clr;

    assign req = '{wr: dp_wr, rd: dp_rd, idx: dp_idx, wdata: dp_wdata};
    assign pl  = '{we: pl_we, idx: pl_addr, data: pl_data};

    pwrctl_route #(.LATE_SILICON(LATE_SILICON)) u_route (
        .bank_en    (bank_en),
        .req        (req),
        .cmos_rdata (cmos_rdata),
        .bank_rdata (bank_rdata),
        .dp_rdata   (dp_rdata),
        .cmos_wr    (cmos_wr),
        .cmos_rd    (cmos_rd),
        .bank_wr    (bank_wr),
        .bank_clr   (bank_clr)
    );

    pwrctl_regfile #(.LATE_SILICON(LATE_SILICON)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .pl         (pl),
        .bank_wr    (bank_wr),
        .bank_clr   (bank_clr),
        .idx        (req.idx),
        .wdata      (req.wdata),
        .rdata      (bank_rdata),
        .arm_byte   (arm_byte),
        .latch_byte (latch_byte)
    );

    pwrctl_softoff u_soft (
        .clk         (clk),
        .rst         (rst),
        .ctl_wr      (ctl_wr),
        .ctl_trig    (ctl_trig),
        .armed       (arm_byte[ARM_BIT]),
        .pwr_off_req (pwr_off_req)
    );

endmodule

// File: rtl/pwrctl_bank_chk.sv
module pwrctl_bank_chk (
    input logic       clk,
    input logic       rst,
    input logic       bank_en,
    input logic [7:0] dp_idx,
    input logic       dp_wr,
    input logic       dp_rd,
    input logic       pl_we,
    input logic [7:0] pl_addr,
    input logic       ctl_wr,
    input logic       ctl_trig,
    input logic       cmos_wr,
    input logic       cmos_rd,
    input logic       pwr_off_req,
    input logic [7:0] arm_q,
    input logic [7:0] latch_q
);

    // R8: request never lasts two cycles
    a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
        pwr_off_req |=> !pwr_off_req);

    // R8: request only follows an armed trigger
    a_r8_armed_source: assert property (@(posedge clk) disable iff (rst)
        pwr_off_req |-> $past(ctl_wr && ctl_trig && arm_q[6]));

    // R5: status byte reads zero after a bank read of it
    a_r5_latch_clears: assert property (@(posedge clk) disable iff (rst)
        (bank_en && dp_rd && (dp_idx == 8'h06) && !(pl_we && (pl_addr == 8'h06)))
        |=> (latch_q == 8'h00));

    // R4: no software write reaches the status byte
    a_r4_latch_holds: assert property (@(posedge clk) disable iff (rst)
        (!(pl_we && (pl_addr == 8'h06)) && !(bank_en && dp_rd && (dp_idx == 8'h06)))
        |=> $stable(latch_q));

    // R2: arm byte changes only through its own index
    a_r2_arm_holds: assert property (@(posedge clk) disable iff (rst)
        (!(bank_en && dp_wr && (dp_idx == 8'h03)) && !(pl_we && (pl_addr == 8'h03)))
        |=> $stable(arm_q));

    // R7: clock RAM strobes quiet while the bank is selected
    a_r7_clock_quiet: assert property (@(posedge clk) disable iff (rst)
        bank_en |-> (!cmos_wr && !cmos_rd));

endmodule

bind pwrctl_bank pwrctl_bank_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bank_en     (bank_en),
    .dp_idx      (dp_idx),
    .dp_wr       (dp_wr),
    .dp_rd       (dp_rd),
    .pl_we       (pl_we),
    .pl_addr     (pl_addr),
    .ctl_wr      (ctl_wr),
    .ctl_trig    (ctl_trig),
    .cmos_wr     (cmos_wr),
    .cmos_rd     (cmos_rd),
    .pwr_off_req (pwr_off_req),
    .arm_q       (arm_byte),
    .latch_q     (latch_byte)
);

// File: tb/pwrctl_bank_tb.sv
module pwrctl_bank_tb;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst;
    logic       bank_en;
    logic [7:0] dp_idx, dp_wdata, cmos_rdata, pl_addr, pl_data;
    logic       dp_wr, dp_rd, pl_we, ctl_wr, ctl_trig;

    logic [7:0] rdata_v [2];
    logic       cw_v [2];
    logic       cr_v [2];
    logic       po_v [2];

    int    total = 0;
    int    bad   = 0;
    string tag   = "R1";

    // index 0 = early variant, 1 = later variant
    bit [7:0] m [2][256];
    bit       armp [2];
    bit       expo [2];

    pwrctl_bank #(.LATE_SILICON(1'b1)) u_dut (
        .clk(clk), .rst(rst), .bank_en(bank_en), .dp_idx(dp_idx),
        .dp_wr(dp_wr), .dp_rd(dp_rd), .dp_wdata(dp_wdata), .dp_rdata(rdata_v[1]),
        .cmos_rdata(cmos_rdata), .cmos_wr(cw_v[1]), .cmos_rd(cr_v[1]),
        .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data),
        .ctl_wr(ctl_wr), .ctl_trig(ctl_trig), .pwr_off_req(po_v[1])
    );

    pwrctl_bank #(.LATE_SILICON(1'b0)) u_dut_early (
        .clk(clk), .rst(rst), .bank_en(bank_en), .dp_idx(dp_idx),
        .dp_wr(dp_wr), .dp_rd(dp_rd), .dp_wdata(dp_wdata), .dp_rdata(rdata_v[0]),
        .cmos_rdata(cmos_rdata), .cmos_wr(cw_v[0]), .cmos_rd(cr_v[0]),
        .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data),
        .ctl_wr(ctl_wr), .ctl_trig(ctl_trig), .pwr_off_req(po_v[0])
    );

    function automatic bit wable(int v, int i);
        if (i >= 2 && i <= 4) return 1'b1;
        if (v == 1 && (i == 5 || i == 7 || i == 8)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit [7:0] rdef(int v, int i);
        if (v == 1) return (i == 4) ? 8'h08 : 8'h00;
        if (i == 3) return 8'h80;
        if (i == 4) return 8'h38;
        if (i == 7) return 8'h01;
        return 8'h00;
    endfunction

    task automatic chk(string what, int v, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s variant=%0d idx=%02h act=%02h exp=%02h",
                     tag, what, v, dp_idx, act, exp);
        end
    endtask

    task automatic check_comb();
        for (int v = 0; v < 2; v++) begin
            chk("rdata", v, rdata_v[v], bank_en ? m[v][dp_idx] : cmos_rdata);
            chk("cmos_wr", v, {7'd0, cw_v[v]}, {7'd0, dp_wr && !bank_en});
            chk("cmos_rd", v, {7'd0, cr_v[v]}, {7'd0, dp_rd && !bank_en});
        end
    endtask

    task automatic model_step();
        for (int v = 0; v < 2; v++) begin
            bit arm;
            arm     = ctl_wr && ctl_trig && m[v][3][6];
            expo[v] = arm && !armp[v];
            armp[v] = arm;
            if (bank_en && dp_wr && wable(v, dp_idx) && !(pl_we && pl_addr == dp_idx))
                m[v][dp_idx] = dp_wdata;
            if (bank_en && dp_rd && dp_idx == 8'h06 && !(pl_we && pl_addr == 8'h06))
                m[v][6] = 8'h00;
            if (pl_we) m[v][pl_addr] = pl_data;
        end
    endtask

    // inputs are set just after a falling edge
    task automatic tick();
        #2 check_comb();
        @(posedge clk);
        model_step();
        @(negedge clk);
        for (int v = 0; v < 2; v++)
            chk("pwr_off_req", v, {7'd0, po_v[v]}, {7'd0, expo[v]});
        dp_wr = 1'b0; dp_rd = 1'b0; pl_we = 1'b0; ctl_wr = 1'b0;
    endtask

    task automatic wr(logic [7:0] i, logic [7:0] d);
        dp_idx = i; dp_wdata = d; dp_wr = 1'b1; tick();
    endtask

    task automatic look(logic [7:0] i);
        dp_idx = i; tick();
    endtask

    initial begin
        #(20 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; bank_en = 1'b1; dp_idx = '0; dp_wdata = '0; cmos_rdata = 8'h5C;
        dp_wr = 0; dp_rd = 0; pl_we = 0; pl_addr = '0; pl_data = '0;
        ctl_wr = 0; ctl_trig = 0;
        for (int v = 0; v < 2; v++) begin
            for (int i = 0; i < 256; i++) m[v][i] = rdef(v, i);
            armp[v] = 0; expo[v] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        tag = "R1";
        for (int i = 0; i < 256; i++) look(8'(i));

        tag = "R2";
        wr(8'h02, 8'hA5); wr(8'h03, 8'h1A); wr(8'h04, 8'h3C);
        look(8'h02); look(8'h03); look(8'h04);

        tag = "R3";
        wr(8'h05, 8'h11); wr(8'h07, 8'h22); wr(8'h08, 8'h33);
        look(8'h05); look(8'h07); look(8'h08);

        tag = "R4";
        wr(8'h00, 8'hFF); wr(8'h01, 8'hEE); wr(8'h06, 8'hDD);
        wr(8'h09, 8'hCC); wr(8'hFF, 8'hBB);
        look(8'h00); look(8'h06); look(8'h09); look(8'hFF);

        tag = "R9";
        pl_we = 1; pl_addr = 8'h06; pl_data = 8'h9C; tick();
        pl_we = 1; pl_addr = 8'h40; pl_data = 8'h71; tick();
        pl_we = 1; pl_addr = 8'h02; pl_data = 8'h66; dp_idx = 8'h02;
        dp_wdata = 8'h99; dp_wr = 1; tick();
        look(8'h02); look(8'h40);

        tag = "R5";
        dp_idx = 8'h06; dp_rd = 1; tick();
        look(8'h06);
        pl_we = 1; pl_addr = 8'h06; pl_data = 8'h3E; tick();
        dp_idx = 8'h06; dp_rd = 1; tick();
        look(8'h06);

        tag = "R6";
        pl_we = 1; pl_addr = 8'h06; pl_data = 8'h47; tick();
        bank_en = 0; cmos_rdata = 8'h77;
        dp_idx = 8'h06; dp_rd = 1; tick();
        wr(8'h02, 8'h12);
        cmos_rdata = 8'h0F; look(8'h04);
        bank_en = 1;
        look(8'h06); look(8'h02);

        tag = "R7";
        cmos_rdata = 8'hAA;
        dp_idx = 8'h04; dp_rd = 1; tick();
        wr(8'h04, 8'h5B);

        tag = "R8";
        wr(8'h03, 8'h80);
        ctl_wr = 1; ctl_trig = 1; tick();
        look(8'h03);
        wr(8'h03, 8'h40);
        ctl_wr = 1; ctl_trig = 1; #2 check_comb();
        @(posedge clk); model_step(); @(negedge clk);
        for (int v = 0; v < 2; v++)
            chk("pwr_off_req", v, {7'd0, po_v[v]}, {7'd0, expo[v]});
        tick();
        look(8'h03);
        ctl_wr = 1; ctl_trig = 0; tick();
        look(8'h03);
        ctl_wr = 1; ctl_trig = 1; tick();
        look(8'h03);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule